// File: doc/BRIEF.md
# Odd-Subtraction Integer Square Root

This block returns the integer square root of an unsigned radicand. It takes away the odd numbers 1, 3, 5, ... from a working remainder, one subtraction per clock cycle, and counts the subtractions. A subtraction that leaves exactly zero ends the run with an exact root. A subtraction that would go below zero ends the run with the count minus one, which is the root rounded down. A non-square input therefore always terminates.

A caller pulses `start` for one cycle with the radicand on `radicand`. After the final subtraction the block raises `done` for one cycle. `root` and `is_square` change on that same edge and keep their values until the next result. A radicand of zero is answered directly, with no subtraction. While a run is in progress the block disregards `start`.

Top module: `isqrt_odd_sub`

## Requirements
- R1: During and directly after reset, `done`, `root` and `is_square` are all 0.
- R2: A run accepted from idle loads the remainder with the radicand and sets both the running count and the odd subtrahend to 1. In every busy cycle exactly one subtraction is made. When the difference is neither zero nor a borrow, the count rises by 1 and the subtrahend by 2, so the subtrahend always equals twice the count minus one.
- R3: When a subtraction leaves exactly zero, `root` takes the count and `is_square` is 1. For example, 36 yields 6 and 16 yields 4.
- R4: When a subtraction would borrow, `root` takes the count minus 1 and `is_square` is 0. For every radicand, `root` is the largest r with r*r <= radicand.
- R5: A radicand of 0 yields `root` = 0 and `is_square` = 1, with zero subtractions.
- R6: Let the edge that samples `start` be T, and let n be the number of subtractions: k for a square k*k (k > 0), k+1 for a non-square whose floor root is k, and 0 for a zero radicand. Then `done` is high in the cycle that follows edge T+n.
- R7: `done` is high for one cycle only. With `start` low it is 0 again in the next cycle.
- R8: A `start` pulse that arrives during a run has no effect. The running result, its timing and the number of `done` pulses are unchanged.
- R9: `root` and `is_square` change only on the edge that raises `done`, and hold between results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a run; taken only when idle |
| radicand | input | WIDTH (8) | Unsigned value whose root is wanted, sampled with `start` |
| done | output | 1 | One-cycle pulse marking a fresh result |
| root | output | WIDTH (8) | Floor square root of the last accepted radicand |
| is_square | output | 1 | 1 when the last radicand was a perfect square |

## Verification
The result is due n cycles after the edge that samples `start`, where n is the subtraction count of R6. The maximum is 16, for a non-square radicand whose floor root is 15. A zero radicand answers on the sampling edge itself. The bench computes n and the floor root for every 8-bit radicand by its own search. It drives inputs on falling edges and counts falling edges from the sampling edge until `done` shows, then compares that count with n and reads the result on the same falling edge. The cycle after each result is also sampled, to confirm that `done` has dropped and that the result still holds. In the overlap scenario the cycle count continues across the ignored pulse.

// File: rtl/isqrt_odd_pkg.sv
package isqrt_odd_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } isq_state_e;
endpackage

// File: rtl/isqrt_odd_ctrl.sv
module isqrt_odd_ctrl
  import isqrt_odd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic rad_zero,
  input  logic step_end,
  output logic load,
  output logic busy
);
  isq_state_e state_q, state_d;

  assign load = start && (state_q == ST_IDLE);
  assign busy = (state_q == ST_BUSY);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (load && !rad_zero) state_d = ST_BUSY;
      ST_BUSY: if (step_end)          state_d = ST_IDLE;
      default:                        state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/isqrt_odd_dp.sv
module isqrt_odd_dp #(
  parameter int WIDTH = 8,
  localparam int HALF  = WIDTH / 2,
  localparam int ODD_W = HALF + 1,
  localparam int CNT_W = HALF + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [WIDTH-1:0] radicand,
  output logic             rad_zero,
  output logic             step_end,
  output logic             done,
  output logic [WIDTH-1:0] root,
  output logic             is_square,
  output logic [ODD_W-1:0] odd_q,
  output logic [CNT_W-1:0] cnt_q
);
  // remainder minus odd subtrahend, with the borrow as the top bit
  function automatic logic [WIDTH:0] take_odd(input logic [WIDTH-1:0] r,
                                              input logic [ODD_W-1:0] o);
    return {1'b0, r} - {{(WIDTH - ODD_W + 1){1'b0}}, o};
  endfunction

  function automatic logic [WIDTH-1:0] widen(input logic [CNT_W-1:0] c);
    return {{(WIDTH - CNT_W){1'b0}}, c};
  endfunction

  logic [WIDTH-1:0] rem_q;
  logic [WIDTH:0]   sub_w;
  logic             borrow_w;
  logic [WIDTH-1:0] diff_w;
  logic             hit_zero;
  logic             hit_borrow;
  logic             zero_load;

  assign sub_w      = take_odd(rem_q, odd_q);
  assign borrow_w   = sub_w[WIDTH];
  assign diff_w     = sub_w[WIDTH-1:0];
  assign hit_zero   = step && !borrow_w && (diff_w == '0);
  assign hit_borrow = step && borrow_w;
  assign step_end   = hit_zero || hit_borrow;
  assign rad_zero   = (radicand == '0);
  assign zero_load  = load && rad_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      odd_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      rem_q <= radicand;
      odd_q <= ODD_W'(1);
      cnt_q <= CNT_W'(1);
    end else if (step && !step_end) begin
      rem_q <= diff_w;
      odd_q <= odd_q + ODD_W'(2);
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done      <= 1'b0;
      root      <= '0;
      is_square <= 1'b0;
    end else begin
      done <= zero_load || step_end;
      if (zero_load) begin
        root      <= '0;
        is_square <= 1'b1;
      end else if (hit_zero) begin
        root      <= widen(cnt_q);
        is_square <= 1'b1;
      end else if (hit_borrow) begin
        root      <= widen(cnt_q - CNT_W'(1));
        is_square <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/isqrt_odd_sub.sv
module isqrt_odd_sub #(
  parameter int WIDTH = 8,
  localparam int HALF  = WIDTH / 2,
  localparam int ODD_W = HALF + 1,
  localparam int CNT_W = HALF + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] radicand,
  output logic             done,
  output logic [WIDTH-1:0] root,
  output logic             is_square
);
  logic             load_w;
  logic             busy_w;
  logic             rad_zero_w;
  logic             step_end_w;
  logic [ODD_W-1:0] odd_w;
  logic [CNT_W-1:0] cnt_w;

  isqrt_odd_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .rad_zero (rad_zero_w),
    .step_end (step_end_w),
    .load     (load_w),
    .busy     (busy_w)
  );

  isqrt_odd_dp #(.WIDTH(WIDTH)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_w),
    .step      (busy_w),
    .radicand  (radicand),
    .rad_zero  (rad_zero_w),
    .step_end  (step_end_w),
    .done      (done),
    .root      (root),
    .is_square (is_square),
    .odd_q     (odd_w),
    .cnt_q     (cnt_w)
  );
endmodule

// File: rtl/isqrt_odd_sub_chk.sv
module isqrt_odd_sub_chk #(
  parameter int WIDTH = 8,
  localparam int HALF  = WIDTH / 2,
  localparam int ODD_W = HALF + 1,
  localparam int CNT_W = HALF + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] radicand,
  input logic             done,
  input logic [WIDTH-1:0] root,
  input logic             is_square,
  input logic             load,
  input logic             busy,
  input logic [ODD_W-1:0] odd_q,
  input logic [CNT_W-1:0] cnt_q
);
  logic [WIDTH-1:0]   cap_q;
  logic [WIDTH-1:0]   lat_q;
  logic [2*WIDTH-1:0] root_x, cap_x, sq_lo, sq_hi;
  logic [CNT_W:0]     odd_from_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= '0;
      lat_q <= '0;
    end else if (load) begin
      cap_q <= radicand;
      lat_q <= '0;
    end else if (busy) begin
      lat_q <= lat_q + WIDTH'(1);
    end
  end

  assign root_x       = {{WIDTH{1'b0}}, root};
  assign cap_x        = {{WIDTH{1'b0}}, cap_q};
  assign sq_lo        = root_x * root_x;
  assign sq_hi        = (root_x + 1'b1) * (root_x + 1'b1);
  assign odd_from_cnt = {cnt_q, 1'b0} - 1'b1;

  AST_FLOOR_ROOT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (sq_lo <= cap_x) && (sq_hi > cap_x)); // R4
  AST_EXACT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (is_square == (sq_lo == cap_x))); // R3
  AST_ODD_LOCKSTEP: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ({1'b0, odd_q} == odd_from_cnt)); // R2
  AST_SUB_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_q == (is_square ? root : root + WIDTH'(1)))); // R6
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(root) && $stable(is_square)); // R9
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(load || busy)); // R7
endmodule

bind isqrt_odd_sub isqrt_odd_sub_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .radicand  (radicand),
  .done      (done),
  .root      (root),
  .is_square (is_square),
  .load      (load_w),
  .busy      (busy_w),
  .odd_q     (odd_w),
  .cnt_q     (cnt_w)
);

// File: tb/isqrt_odd_sub_tb.sv
module isqrt_odd_sub_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] radicand = '0;
  logic       done;
  logic [7:0] root;
  logic       is_square;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  isqrt_odd_sub #(.WIDTH(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .radicand(radicand),
    .done(done), .root(root), .is_square(is_square)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_root(input int x);
    int k = 0;
    while ((k + 1) * (k + 1) <= x) k++;
    return k;
  endfunction

  function automatic int ref_subs(input int x);
    int k = ref_root(x);
    if (x == 0) return 0;
    return (k * k == x) ? k : k + 1;
  endfunction

  // drive one request; lat counts falling edges after the sampling edge
  task automatic run_op(input int x, output int r, output int sq, output int lat);
    @(negedge clk);
    start = 1'b1;
    radicand = 8'(x);
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 64) begin
      @(negedge clk);
      lat++;
    end
    r = int'(root);
    sq = int'(is_square);
  endtask

  task automatic check_one(input int x, input string tag);
    int r, sq, lat, r_next;
    run_op(x, r, sq, lat);
    chk($sformatf("R4 %s root of %0d", tag, x), r, ref_root(x));
    chk($sformatf("R3 R4 %s square flag of %0d", tag, x), sq,
        (ref_root(x) * ref_root(x) == x) ? 1 : 0);
    chk($sformatf("R2 R6 %s cycles for %0d", tag, x), lat, ref_subs(x));
    @(negedge clk);
    r_next = int'(root);
    chk($sformatf("R7 %s done dropped after %0d", tag, x), int'(done), 0);
    chk($sformatf("R9 %s root held after %0d", tag, x), r_next, ref_root(x));
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    chk("R1 done in reset", int'(done), 0);
    chk("R1 root in reset", int'(root), 0);
    chk("R1 flag in reset", int'(is_square), 0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1 done after reset", int'(done), 0);
    chk("R1 root after reset", int'(root), 0);
  endtask

  task automatic t_named_values;
    check_one(36, "thirty-six");
    check_one(16, "sixteen");
    check_one(0, "R5 zero");
    check_one(255, "top");
    check_one(225, "largest square");
  endtask

  task automatic t_sweep;
    for (int x = 0; x < 256; x++) check_one(x, "sweep");
  endtask

  task automatic t_busy_start;
    int lat = 0;
    int extra = 0;
    @(negedge clk);
    start = 1'b1;
    radicand = 8'd200;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    while (!done && lat < 64) begin
      @(negedge clk);
      lat++;
      if (lat == 3) begin start = 1'b1; radicand = 8'd4; end
      if (lat == 4) start = 1'b0;
    end
    chk("R8 root of running op", int'(root), 14);
    chk("R8 flag of running op", int'(is_square), 0);
    chk("R8 cycles of running op", lat, 15);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (done) extra++;
    end
    chk("R8 no extra done", extra, 0);
    chk("R8 R9 root still held", int'(root), 14);
  endtask

  task automatic t_zero_then_square;
    int r, sq, lat;
    run_op(0, r, sq, lat);
    chk("R5 zero root", r, 0);
    chk("R5 zero flag", sq, 1);
    chk("R5 zero cycles", lat, 0);
    run_op(49, r, sq, lat);
    chk("R3 root of 49", r, 7);
    chk("R3 flag of 49", sq, 1);
    chk("R6 cycles of 49", lat, 7);
  endtask

  initial begin
    t_reset_state();
    t_named_values();
    t_busy_start();
    t_zero_then_square();
    t_sweep();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule